// File: doc/BRIEF.md
# Framed parallel-to-serial converter

The block turns a parallel word into a serial bit stream, one bit per clock cycle, lowest bit first. A single-cycle launch pulse starts a frame. The first bit leaves in that same cycle, with no register in between. Two flags travel with the stream. `serFirst` is high with bit 0 and `serLast` is high with the top bit, so a receiver can find frame edges without counting.

A bit counter is the only state in the block. Reset loads it with the word width, which is the idle value. A launch forces the effective count to zero in the cycle it arrives. While the counter is idle, all three outputs are held low.

The word input is not captured. It is read on every cycle, and the user keeps it stable during a frame. A launch pulse during a frame abandons that frame and starts again at bit 0.

Top module: `framed_serializer`

## Requirements
- R1: After reset is released, and with no launch, `serOut`, `serFirst` and `serLast` are all 0.
- R2: In the cycle `launch` is 1, `serOut` equals `dataIn[0]`, `serFirst` is 1 and `serLast` is 0, with no cycle of delay.
- R3: In the k-th cycle after a launch, for 1 <= k <= WORD_W-2 and with no new launch, `serOut` equals `dataIn[k]` and both flags are 0.
- R4: In cycle WORD_W-1 after a launch, `serOut` equals `dataIn[WORD_W-1]`, `serLast` is 1 and `serFirst` is 0.
- R5: From the cycle after the last bit until the next launch, all three outputs are 0, and no further bits are sent.
- R6: `dataIn` is not latched. A change during a frame shows up on `serOut` for every bit position sent after the change.
- R7: A launch in the middle of a frame restarts at bit 0 with `serFirst` set. `serFirst` is never 1 without `launch`.
- R8: A launch in the cycle of the last bit, or in the cycle right after it, starts a new frame at once.
- R9: `serFirst` and `serLast` are never 1 in the same cycle (WORD_W >= 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; loads the idle count |
| dataIn | input | WORD_W | Parallel word, read live every cycle |
| launch | input | 1 | One-cycle pulse that starts or restarts a frame |
| serOut | output | 1 | Serial data, LSB first; 0 when idle |
| serFirst | output | 1 | High with bit 0 of a frame |
| serLast | output | 1 | High with the final bit of a frame |

## Verification
The assertions track the cycles since the last launch with their own counter. On every cycle they check:
- the bit position and flags of that cycle (R2, R3 and R4);
- the silent idle state after reset and after a frame (R1 and R5);
- that the two flags never overlap (R9);
- that a first-bit flag always comes with a launch (R7).

Only the bench scenarios can show:
- that changing the word mid-frame alters the later bits (R6);
- that relaunching mid-frame, on the last bit, or right after it sends the correct whole word a second time (R7 and R8);
- that bit values are correct across several distinct data patterns.

// File: rtl/ser_pkg.sv
package ser_pkg;

  // Strobes passed from the control to the datapath each cycle.
  typedef struct packed {
    logic active;     // a bit is being sent this cycle
    logic markFirst;  // this bit is bit 0 of the frame
    logic markLast;   // this bit is the top bit of the frame
  } serStrobeT;

endpackage

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import ser_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CNT_W  = $clog2(WORD_W + 1),
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  output serStrobeT        strobe,
  output logic [IDX_W-1:0] bitIdx
);

  localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] effCount;
  logic [CNT_W-1:0] nextCount;

  // A launch overrides the stored count within the same cycle.
  assign effCount = launch ? '0 : count;
  assign bitIdx   = effCount[IDX_W-1:0];

  always_comb begin
    strobe    = '0;
    nextCount = count;
    if (effCount == '0) begin
      strobe.active    = 1'b1;
      strobe.markFirst = 1'b1;
      nextCount        = effCount + 1'b1;
    end else if (effCount == LAST_CNT) begin
      strobe.active    = 1'b1;
      strobe.markLast  = 1'b1;
      nextCount        = IDLE_CNT;
    end else if (effCount < LAST_CNT) begin
      strobe.active    = 1'b1;
      nextCount        = effCount + 1'b1;
    end else begin
      nextCount        = IDLE_CNT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count <= IDLE_CNT;
    else     count <= nextCount;
  end

endmodule

// File: rtl/ser_dpath.sv
module ser_dpath
  import ser_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] dataIn,
  input  serStrobeT         strobe,
  input  logic [IDX_W-1:0]  bitIdx,
  output logic              serOut,
  output logic              serFirst,
  output logic              serLast
);

  logic [WORD_W-1:0] hit;

  // AND-OR bit select: one term per bit position, gated by the active strobe.
  for (genvar g = 0; g < WORD_W; g++) begin : gSel
    assign hit[g] = strobe.active && (bitIdx == IDX_W'(g)) && dataIn[g];
  end

  assign serOut   = |hit;
  assign serFirst = strobe.markFirst;
  assign serLast  = strobe.markLast;

endmodule

// File: rtl/framed_serializer.sv
module framed_serializer
  import ser_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              launch,
  output logic              serOut,
  output logic              serFirst,
  output logic              serLast
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int IDX_W = $clog2(WORD_W);

  serStrobeT        strobe;
  logic [IDX_W-1:0] bitIdx;

  ser_ctrl #(.WORD_W(WORD_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .strobe (strobe),
    .bitIdx (bitIdx)
  );

  ser_dpath #(.WORD_W(WORD_W), .IDX_W(IDX_W)) uDpath (
    .dataIn   (dataIn),
    .strobe   (strobe),
    .bitIdx   (bitIdx),
    .serOut   (serOut),
    .serFirst (serFirst),
    .serLast  (serLast)
  );

endmodule

// File: rtl/ser_chk.sv
module ser_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] dataIn,
  input logic              launch,
  input logic              serOut,
  input logic              serFirst,
  input logic              serLast
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  // Cycles since the last launch; saturates at CAP, which also means idle.
  logic [CNT_W-1:0] sinceCnt;
  always_ff @(posedge clk) begin
    if (rst)                  sinceCnt <= CAP;
    else if (launch)          sinceCnt <= CNT_W'(1);
    else if (sinceCnt != CAP) sinceCnt <= sinceCnt + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !launch) |-> (!serOut && !serFirst && !serLast));

  p_first_on_launch_r2: assert property (@(posedge clk) disable iff (rst)
    launch |-> (serFirst && !serLast && serOut == dataIn[0]));

  p_middle_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (!launch && sinceCnt >= CNT_W'(1) && sinceCnt < LAST)
      |-> (!serFirst && !serLast && serOut == dataIn[sinceCnt[IDX_W-1:0]]));

  p_last_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (!launch && sinceCnt == LAST)
      |-> (serLast && !serFirst && serOut == dataIn[WORD_W-1]));

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!launch && sinceCnt == CAP) |-> (!serOut && !serFirst && !serLast));

  p_first_needs_launch_r7: assert property (@(posedge clk) disable iff (rst)
    serFirst |-> launch);

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(serFirst && serLast));

endmodule

bind framed_serializer ser_chk #(.WORD_W(WORD_W)) uChk (
  .clk      (clk),
  .rst      (rst),
  .dataIn   (dataIn),
  .launch   (launch),
  .serOut   (serOut),
  .serFirst (serFirst),
  .serLast  (serLast)
);

// File: tb/tb_framed_serializer.sv
`timescale 1ns/1ps
module tb_framed_serializer;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] dataIn = '0;
  logic         launch = 1'b0;
  logic         serOut, serFirst, serLast;

  always #2.5 clk = ~clk;

  framed_serializer #(.WORD_W(N)) dut (
    .clk(clk), .rst(rst), .dataIn(dataIn), .launch(launch),
    .serOut(serOut), .serFirst(serFirst), .serLast(serLast)
  );

  typedef struct {
    logic  o;
    logic  f;
    logic  l;
    string tag;
  } expItemT;

  expItemT expQ[$];
  int checks = 0;
  int failures = 0;
  int pos = N;        // bench view of bit position; N means idle
  bit finished = 1'b0;

  // Driver: one cycle of stimulus, and the expected outputs for that cycle.
  task automatic step(input logic go, input logic [N-1:0] word, input string tagOvr);
    expItemT e;
    @(negedge clk);
    launch = go;
    dataIn = word;
    if (go) pos = 0;
    if (pos < N) begin
      e.o = word[pos];
      e.f = (pos == 0);
      e.l = (pos == N - 1);
      e.tag = (pos == 0) ? "R2" : ((pos == N - 1) ? "R4" : "R3");
    end else begin
      e.o = 1'b0; e.f = 1'b0; e.l = 1'b0;
      e.tag = "R5";
    end
    if (tagOvr != "") e.tag = tagOvr;
    expQ.push_back(e);
    if (pos < N) pos++;
  endtask

  task automatic frame(input logic [N-1:0] word, input int idleAfter);
    step(1'b1, word, "");
    for (int i = 1; i < N; i++) step(1'b0, word, "");
    for (int i = 0; i < idleAfter; i++) step(1'b0, word, "");
  endtask

  // Monitor: compares the outputs with the queue away from the clock edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItemT e;
        e = expQ.pop_front();
        checks++;
        if ({serOut, serFirst, serLast} !== {e.o, e.f, e.l}) begin
          failures++;
          $display("FAIL %s: out/first/last actual=%b%b%b expected=%b%b%b",
                   e.tag, serOut, serFirst, serLast, e.o, e.f, e.l);
        end
        checks++;
        if (serFirst === 1'b1 && serLast === 1'b1) begin
          failures++;
          $display("FAIL R9: first/last actual=11 expected=not both 1");
        end
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: quiet after reset.
    for (int i = 0; i < 3; i++) step(1'b0, 8'hFF, "R1");
    // R2 R3 R4 R5: full frames with several patterns, then idle.
    frame(8'hB5, 3);
    frame(8'h01, 2);
    frame(8'h80, 2);
    frame(8'hFF, 2);
    frame(8'h00, 1);
    // R6: the word changes mid-frame, and later bits follow the new value.
    step(1'b1, 8'h0F, "R6");
    step(1'b0, 8'h0F, "R6");
    step(1'b0, 8'h0F, "R6");
    for (int i = 3; i < N; i++) step(1'b0, 8'hF0, "R6");
    step(1'b0, 8'hF0, "R5");
    // R7: relaunch in the middle of a frame restarts at bit 0.
    step(1'b1, 8'hA5, "");
    for (int i = 1; i < 4; i++) step(1'b0, 8'hA5, "");
    step(1'b1, 8'h3C, "R7");
    for (int i = 1; i < N; i++) step(1'b0, 8'h3C, "R7");
    step(1'b0, 8'h3C, "R5");
    // R8: relaunch on the last-bit cycle.
    step(1'b1, 8'h69, "");
    for (int i = 1; i < N - 1; i++) step(1'b0, 8'h69, "");
    step(1'b1, 8'h96, "R8");
    for (int i = 1; i < N; i++) step(1'b0, 8'h96, "R8");
    // R8: launch in the cycle right after the last bit (back to back).
    step(1'b1, 8'h5A, "R8");
    for (int i = 1; i < N; i++) step(1'b0, 8'h5A, "R8");
    for (int i = 0; i < 3; i++) step(1'b0, 8'h5A, "R5");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule